// File: doc/BRIEF.md
# Four-Element Configurable Register Bank

This block holds four single-bit storage elements that share one clock, one clock enable and one local clear input. Each element can be built as an edge-triggered flip-flop or as a level-sensitive latch. Each element has its own clear value, which can be 0 or 1, and its own choice of data source. The source is either the function input `fn_d` or the direct input `dir_d`, which bypasses the function logic.

Every behavioural choice is fixed at elaboration by a parameter, so a placement tool can stamp out the variant that a netlist asks for. The choices are:

- the local clear mode: off, synchronous or asynchronous;
- the polarity of the clock, the enable and the local clear;
- whether the clock enable is used at all;
- whether a synchronous clear waits for the enable.

An active-low global clear always acts asynchronously and loads every element with its own clear value.

Top module: `rsr_bank`

## Requirements
- R1: The clock, the clock enable and the local clear act on all four elements together. One active edge with the enable asserted updates every flip-flop element in that edge.
- R2: On a clear, element i takes bit i of `SET_MASK`: 1 means it goes to 1, and 0 means it goes to 0.
- R3: While `gsr_n` is low, the outputs equal `SET_MASK` at once, without waiting for a clock edge.
- R4: `LSR_MODE` selects the local clear mode: `LSR_OFF` (the default), `LSR_SYNC` or `LSR_ASYNC`. In `LSR_OFF` the `lsr` input has no effect. In `LSR_SYNC` the clear acts only at an active clock edge.
- R5: In `LSR_ASYNC` an active `lsr` forces the outputs to `SET_MASK` at once and overrides clocked data for as long as it stays active.
- R6: With `CE_USED`=1, an inactive enable holds every element. With `CE_USED`=0, the elements load data on every active clock phase whatever `ce` is.
- R7: Element i loads `dir_d[i]` when bit i of `DIRECT_MASK` is 1, and `fn_d[i]` when that bit is 0.
- R8: `CLK_INV`, `CE_INV` and `LSR_INV` each invert the sense of their control input. With `CLK_INV`=1, flip-flops capture on the falling edge of `clk`.
- R9: With `SYNC_OVER_CE`=1, a synchronous clear acts whatever the enable is. With `SYNC_OVER_CE`=0, it acts only when the enable is active.
- R10: An element whose bit in `LATCH_MASK` is 1 is a latch. It follows its data while the internal clock is high and holds its value while the clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, or latch gate |
| gsr_n | input | 1 | Global clear, active low, asynchronous |
| lsr | input | 1 | Local clear; its polarity and mode are set by parameters |
| ce | input | 1 | Clock enable; its polarity is set by a parameter |
| fn_d | input | N | Data from the function logic |
| dir_d | input | N | Direct data that bypasses the function logic |
| q | output | N | Element outputs |

## Verification
The bench goes after the points where the clear and the enable meet. If the synchronous clear were wired as an asynchronous one, the output would change before the edge. If the priority bit were ignored, a clear with the enable inactive would either always happen or never happen. If an element took the wrong clear value, it would come out inverted. For latch elements, the bench changes the data inside the high and low clock phases. A latch built as a flip-flop would then miss the change while the clock is high, and a latch that is always open would leak the change while the clock is low. An inverted-clock instance is sampled just after the rising edge, where it must not yet have moved.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
    typedef enum logic [1:0] {
        LSR_OFF   = 2'd0,
        LSR_SYNC  = 2'd1,
        LSR_ASYNC = 2'd2
    } lsr_mode_e;
endpackage

// File: rtl/rsr_ctl.sv
module rsr_ctl
    import rsr_pkg::*;
#(
    parameter lsr_mode_e LSR_MODE = LSR_OFF,
    parameter bit        CLK_INV  = 1'b0,
    parameter bit        CE_INV   = 1'b0,
    parameter bit        LSR_INV  = 1'b0,
    parameter bit        CE_USED  = 1'b1
) (
    input  logic clk,
    input  logic gsr_n,
    input  logic lsr,
    input  logic ce,
    output logic clk_int,
    output logic ce_int,
    output logic sync_clr,
    output logic async_clr
);
    logic lsr_act;

    generate
        if (CLK_INV) begin : g_clk_inv
            assign clk_int = ~clk;
        end else begin : g_clk_dir
            assign clk_int = clk;
        end

        if (CE_USED) begin : g_ce_on
            assign ce_int = ce ^ CE_INV;
        end else begin : g_ce_off
            assign ce_int = 1'b1;
        end
    endgenerate

    assign lsr_act   = lsr ^ LSR_INV;
    assign sync_clr  = (LSR_MODE == LSR_SYNC) && lsr_act;
    assign async_clr = !gsr_n || ((LSR_MODE == LSR_ASYNC) && lsr_act);
endmodule

// File: rtl/rsr_cell.sv
module rsr_cell #(
    parameter bit IS_LATCH     = 1'b0,
    parameter bit RST_VAL      = 1'b0,
    parameter bit SYNC_OVER_CE = 1'b1
) (
    input  logic clk_int,
    input  logic ce_int,
    input  logic sync_clr,
    input  logic async_clr,
    input  logic d,
    output logic q
);
    logic take_clr;

    assign take_clr = sync_clr && (SYNC_OVER_CE || ce_int);

    generate
        if (IS_LATCH) begin : g_latch
            always_latch begin
                if (async_clr) begin
                    q <= RST_VAL;
                end else if (clk_int) begin
                    if (take_clr) begin
                        q <= RST_VAL;
                    end else if (ce_int) begin
                        q <= d;
                    end
                end
            end
        end else begin : g_flop
            always_ff @(posedge clk_int or posedge async_clr) begin
                if (async_clr) begin
                    q <= RST_VAL;
                end else if (take_clr) begin
                    q <= RST_VAL;
                end else if (ce_int) begin
                    q <= d;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/rsr_bank.sv
module rsr_bank
    import rsr_pkg::*;
#(
    parameter int          N            = 4,
    parameter logic [N-1:0] LATCH_MASK  = '0,
    parameter logic [N-1:0] SET_MASK    = '0,
    parameter logic [N-1:0] DIRECT_MASK = '0,
    parameter lsr_mode_e   LSR_MODE     = LSR_OFF,
    parameter bit          SYNC_OVER_CE = 1'b1,
    parameter bit          CE_USED      = 1'b1,
    parameter bit          CLK_INV      = 1'b0,
    parameter bit          CE_INV       = 1'b0,
    parameter bit          LSR_INV      = 1'b0
) (
    input  logic         clk,
    input  logic         gsr_n,
    input  logic         lsr,
    input  logic         ce,
    input  logic [N-1:0] fn_d,
    input  logic [N-1:0] dir_d,
    output logic [N-1:0] q
);
    logic         clk_int;
    logic         ce_int;
    logic         sync_clr;
    logic         async_clr;
    logic [N-1:0] d_sel;

    rsr_ctl #(
        .LSR_MODE (LSR_MODE),
        .CLK_INV  (CLK_INV),
        .CE_INV   (CE_INV),
        .LSR_INV  (LSR_INV),
        .CE_USED  (CE_USED)
    ) u_ctl (
        .clk       (clk),
        .gsr_n     (gsr_n),
        .lsr       (lsr),
        .ce        (ce),
        .clk_int   (clk_int),
        .ce_int    (ce_int),
        .sync_clr  (sync_clr),
        .async_clr (async_clr)
    );

    generate
        for (genvar i = 0; i < N; i++) begin : g_elem
            if (DIRECT_MASK[i]) begin : g_src_dir
                assign d_sel[i] = dir_d[i];
            end else begin : g_src_fn
                assign d_sel[i] = fn_d[i];
            end

            rsr_cell #(
                .IS_LATCH     (LATCH_MASK[i]),
                .RST_VAL      (SET_MASK[i]),
                .SYNC_OVER_CE (SYNC_OVER_CE)
            ) u_cell (
                .clk_int   (clk_int),
                .ce_int    (ce_int),
                .sync_clr  (sync_clr),
                .async_clr (async_clr),
                .d         (d_sel[i]),
                .q         (q[i])
            );
        end
    endgenerate
endmodule

// File: rtl/rsr_bank_chk.sv
module rsr_bank_chk
    import rsr_pkg::*;
#(
    parameter int          N            = 4,
    parameter logic [N-1:0] LATCH_MASK  = '0,
    parameter logic [N-1:0] SET_MASK    = '0,
    parameter logic [N-1:0] DIRECT_MASK = '0,
    parameter lsr_mode_e   LSR_MODE     = LSR_OFF,
    parameter bit          SYNC_OVER_CE = 1'b1,
    parameter bit          CE_USED      = 1'b1,
    parameter bit          CLK_INV      = 1'b0,
    parameter bit          CE_INV       = 1'b0,
    parameter bit          LSR_INV      = 1'b0
) (
    input logic         clk,
    input logic         gsr_n,
    input logic         lsr,
    input logic         ce,
    input logic [N-1:0] fn_d,
    input logic [N-1:0] dir_d,
    input logic [N-1:0] q
);
    logic clk_act;
    logic lsr_on;
    logic ce_on;
    logic sync_on;
    logic hold_off;

    assign clk_act  = clk ^ CLK_INV;
    assign lsr_on   = lsr ^ LSR_INV;
    assign ce_on    = CE_USED ? (ce ^ CE_INV) : 1'b1;
    assign sync_on  = (LSR_MODE == LSR_SYNC) && lsr_on;
    assign hold_off = !gsr_n || ((LSR_MODE == LSR_ASYNC) && lsr_on);

    always @(negedge clk) begin
        if (!gsr_n) begin
            AST_GSR_FORCE: assert (q == SET_MASK); // R3
        end
        if ((LSR_MODE == LSR_ASYNC) && lsr_on) begin
            AST_ASYNC_LSR: assert (q == SET_MASK); // R5
        end
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            if (!LATCH_MASK[i]) begin : g_flop_chk
                AST_CE_HOLD: assert property (@(posedge clk_act) disable iff (hold_off)
                    (!ce_on && !sync_on) |=> (q[i] == $past(q[i]))); // R6
                AST_LOAD_SRC: assert property (@(posedge clk_act) disable iff (hold_off)
                    (ce_on && !sync_on) |=> (q[i] == $past(DIRECT_MASK[i] ? dir_d[i] : fn_d[i]))); // R7
                AST_SYNC_CLR: assert property (@(posedge clk_act) disable iff (hold_off)
                    (sync_on && (SYNC_OVER_CE || ce_on)) |=> (q[i] == SET_MASK[i])); // R9
                AST_SYNC_BLOCKED: assert property (@(posedge clk_act) disable iff (hold_off)
                    (sync_on && !SYNC_OVER_CE && !ce_on) |=> $stable(q[i])); // R9
            end
        end
    endgenerate
endmodule

bind rsr_bank rsr_bank_chk #(
    .N            (N),
    .LATCH_MASK   (LATCH_MASK),
    .SET_MASK     (SET_MASK),
    .DIRECT_MASK  (DIRECT_MASK),
    .LSR_MODE     (LSR_MODE),
    .SYNC_OVER_CE (SYNC_OVER_CE),
    .CE_USED      (CE_USED),
    .CLK_INV      (CLK_INV),
    .CE_INV       (CE_INV),
    .LSR_INV      (LSR_INV)
) u_chk (
    .clk   (clk),
    .gsr_n (gsr_n),
    .lsr   (lsr),
    .ce    (ce),
    .fn_d  (fn_d),
    .dir_d (dir_d),
    .q     (q)
);

// File: tb/tb_rsr_bank.sv
`timescale 1ns/1ps
module tb_rsr_bank;
    import rsr_pkg::*;

    logic       clk = 1'b0;
    logic       gsr_n = 1'b0;
    logic [3:0] fn_d = 4'b0000;
    logic [3:0] dir_d = 4'b0000;
    logic       lsr_a = 1'b1, ce_a = 1'b0;
    logic       lsr_b = 1'b0, ce_b = 1'b0;
    logic       lsr_c = 1'b0, ce_c = 1'b1;
    logic       lsr_d = 1'b0, ce_d = 1'b0;
    logic [3:0] q_a, q_b, q_c, q_d;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    // Main instance: flops, clear value 0101, bits 1:0 from dir_d,
    // synchronous clear active low, clear ignores enable
    rsr_bank #(.N(4), .LATCH_MASK(4'b0000), .SET_MASK(4'b0101), .DIRECT_MASK(4'b0011),
               .LSR_MODE(LSR_SYNC), .SYNC_OVER_CE(1'b1), .CE_USED(1'b1),
               .CLK_INV(1'b0), .CE_INV(1'b0), .LSR_INV(1'b1))
        dut (.clk(clk), .gsr_n(gsr_n), .lsr(lsr_a), .ce(ce_a), .fn_d(fn_d), .dir_d(dir_d), .q(q_a));

    // Latches on bits 3:2, asynchronous clear, enable unused, clear value 1001, all from dir_d
    rsr_bank #(.N(4), .LATCH_MASK(4'b1100), .SET_MASK(4'b1001), .DIRECT_MASK(4'b1111),
               .LSR_MODE(LSR_ASYNC), .SYNC_OVER_CE(1'b1), .CE_USED(1'b0),
               .CLK_INV(1'b0), .CE_INV(1'b0), .LSR_INV(1'b0))
        dut_b (.clk(clk), .gsr_n(gsr_n), .lsr(lsr_b), .ce(ce_b), .fn_d(fn_d), .dir_d(dir_d), .q(q_b));

    // Inverted clock, active-low enable, synchronous clear that waits for enable
    rsr_bank #(.N(4), .LATCH_MASK(4'b0000), .SET_MASK(4'b0000), .DIRECT_MASK(4'b0000),
               .LSR_MODE(LSR_SYNC), .SYNC_OVER_CE(1'b0), .CE_USED(1'b1),
               .CLK_INV(1'b1), .CE_INV(1'b1), .LSR_INV(1'b0))
        dut_c (.clk(clk), .gsr_n(gsr_n), .lsr(lsr_c), .ce(ce_c), .fn_d(fn_d), .dir_d(dir_d), .q(q_c));

    // All parameters at default
    rsr_bank dut_d (.clk(clk), .gsr_n(gsr_n), .lsr(lsr_d), .ce(ce_d), .fn_d(fn_d), .dir_d(dir_d), .q(q_d));

    // {lsr_n, ce, fn_d, dir_d, expected q_a}
    localparam logic [13:0] VEC [8] = '{
        {1'b1, 1'b1, 4'b1010, 4'b0110, 4'b1010},
        {1'b1, 1'b0, 4'b0101, 4'b1111, 4'b1010},
        {1'b1, 1'b1, 4'b0000, 4'b1111, 4'b0011},
        {1'b0, 1'b0, 4'b1111, 4'b0000, 4'b0101},
        {1'b1, 1'b1, 4'b1100, 4'b0001, 4'b1101},
        {1'b0, 1'b1, 4'b0000, 4'b0000, 4'b0101},
        {1'b1, 1'b1, 4'b0011, 4'b1100, 4'b0000},
        {1'b1, 1'b1, 4'b1111, 4'b1111, 4'b1111}
    };

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic next_cycle();
        @(negedge clk);
        #1;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) next_cycle();
        chk("R2 reset main", q_a, 4'b0101);
        chk("R2 reset latch bank", q_b, 4'b1001);
        chk("R2 reset inv bank", q_c, 4'b0000);
        chk("R2 reset default", q_d, 4'b0000);
        gsr_n = 1'b1;

        // R1 R6 R7 R9 vector walk on the main instance
        for (int k = 0; k < 8; k++) begin
            lsr_a = VEC[k][13];
            ce_a  = VEC[k][12];
            fn_d  = VEC[k][11:8];
            dir_d = VEC[k][7:4];
            next_cycle();
            chk($sformatf("R1 R7 vector %0d", k), q_a, VEC[k][3:0]);
        end

        // R4: synchronous clear must wait for the edge
        lsr_a = 1'b0; ce_a = 1'b0;
        #1;
        chk("R4 sync clear before edge", q_a, 4'b1111);
        next_cycle();
        chk("R4 sync clear after edge", q_a, 4'b0101);

        // R3: global clear acts mid-cycle
        lsr_a = 1'b1; ce_a = 1'b1; fn_d = 4'b1111; dir_d = 4'b1111;
        next_cycle();
        chk("R1 reload", q_a, 4'b1111);
        gsr_n = 1'b0;
        #1;
        chk("R3 gsr immediate main", q_a, 4'b0101);
        chk("R3 gsr immediate latch bank", q_b, 4'b1001);
        next_cycle();
        gsr_n = 1'b1;

        // dut_b: enable unused, direct source, latch bits
        ce_b = 1'b0; lsr_b = 1'b0; dir_d = 4'b0110;
        next_cycle();
        chk("R6 enable unused loads", q_b, 4'b0110);
        @(posedge clk);
        #1 dir_d = 4'b1111;
        #0.5 chk("R10 latch transparent while high", q_b, 4'b1110);
        @(negedge clk);
        #1 dir_d = 4'b0000;
        #0.5 chk("R10 latch holds while low", q_b, 4'b1110);
        next_cycle();
        lsr_b = 1'b1;
        #0.5 chk("R5 async clear immediate", q_b, 4'b1001);
        next_cycle();
        chk("R5 async clear overrides data", q_b, 4'b1001);
        lsr_b = 1'b0;
        next_cycle();
        chk("R7 direct source ignores fn_d", q_b, 4'b0000);

        // dut_c: inverted clock, active-low enable, clear waits for enable
        fn_d = 4'b1111; ce_c = 1'b0; lsr_c = 1'b0;
        @(posedge clk);
        #1 chk("R8 inverted clock no rise capture", q_c, 4'b0000);
        next_cycle();
        chk("R8 inverted clock/enable capture", q_c, 4'b1111);
        ce_c = 1'b1; lsr_c = 1'b1;
        next_cycle();
        chk("R9 clear blocked by enable", q_c, 4'b1111);
        ce_c = 1'b0;
        next_cycle();
        chk("R9 clear with enable", q_c, 4'b0000);
        lsr_c = 1'b0; ce_c = 1'b1; fn_d = 4'b0101;
        next_cycle();
        chk("R6 R8 inactive enable holds", q_c, 4'b0000);

        // dut_d: local clear off by default
        lsr_d = 1'b1; ce_d = 1'b1; fn_d = 4'b1010;
        next_cycle();
        chk("R4 clear disabled by default", q_d, 4'b1010);
        fn_d = 4'b0110; ce_d = 1'b0;
        next_cycle();
        chk("R6 default hold", q_d, 4'b1010);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule